// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block remembers where control transfer instructions went the last time they were taken. It holds one entry per instruction. The fetch side presents the address of an instruction's last byte, and on the next clock the block reports whether that address is held, the way it occupies, and the stored target. A miss means fall-through: the lookup returns no hit and a zero target. A companion direction predictor can be indexed by the returned set and way.

The resolve side reports each finished branch through an update port. It gives the last-byte address, whether the branch was taken, the actual target, and the address just after the instruction. An entry is created only the first time a branch is taken, and never for a jump to its own next address. After that the entry stays valid until a different branch in the same set takes its way.

Only one target is kept per entry. Every taken resolution overwrites it, so indirect jumps are predicted to their last target. In a full set the victim is chosen by an internal LFSR whose seed is a parameter.

Top module: `btb`

## Requirements
- R1: A synchronous active-high reset invalidates every entry and loads the LFSR with LFSR_SEED; after reset every lookup misses.
- R2: A lookup presented at one rising edge is reported after that edge on lk_hit, lk_way and lk_target. On a hit, lk_way is the way index and lk_target is the stored target. On a miss, lk_hit=0, lk_way=0 and lk_target=0, meaning fall-through.
- R3: The set is address bits [5:2] and the tag is bits [31:6]. Bits [1:0] are ignored, so two last-byte addresses in the same 4-byte word use the same entry.
- R4: An update with upd_taken=0 that misses allocates nothing.
- R5: An update with upd_taken=1 that misses, and whose upd_target differs from upd_next, allocates an entry in the lowest-numbered invalid way of its set and stores upd_target there.
- R6: A taken update whose upd_target equals upd_next never allocates an entry.
- R7: An update with upd_taken=0 that hits leaves the entry valid and its target unchanged.
- R8: A taken update that hits overwrites the stored target with upd_target, in the same way.
- R9: When the set is full, the victim way is the low log2(WAYS) bits of an 8-bit LFSR. The LFSR shifts left and brings in s[7]^s[5]^s[4]^s[3]. It advances only when a random victim is used. Entries in other sets are untouched.
- R10: A lookup and an update in the same cycle return the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_addr | input | 32 | Last-byte address to look up |
| lk_hit | output | 1 | Registered hit flag for the previous lookup |
| lk_way | output | 4 | Way of the hit, 0 on a miss |
| lk_target | output | 32 | Stored target, 0 on a miss |
| upd_en | input | 1 | Resolved branch is being reported |
| upd_addr | input | 32 | Last-byte address of the resolved branch |
| upd_taken | input | 1 | Branch was taken |
| upd_target | input | 32 | Actual target of the branch |
| upd_next | input | 32 | Address immediately after the instruction |

## Verification
Four rules are checked on every cycle. Valid entries never disappear outside reset. A not-taken update never changes the set of valid entries. A jump to its own next address allocates nothing. No update creates more than one entry. The LFSR also never reaches its stuck zero state. Other behaviour can only be shown by the bench's scenarios against its reference model: which way is chosen, what target comes back, word aliasing, set isolation under random replacement, and the old-contents result of a lookup that collides with an update.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int LFSR_W = 8;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction
endpackage

// File: rtl/btb_lfsr.sv
module btb_lfsr #(
  parameter logic [7:0] SEED = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  output logic [7:0] state
);
  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= btb_pkg::lfsr_step(state);
  end
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int WAYS = 16,
  localparam int WAY_BITS = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]     row_valid,
  input  logic [WAY_BITS-1:0] rnd_way,
  output logic [WAY_BITS-1:0] victim,
  output logic                use_rnd
);
  logic [WAY_BITS-1:0] free_way;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!row_valid[w]) free_way = WAY_BITS'(w);
  end

  assign use_rnd = &row_valid;
  assign victim  = use_rnd ? rnd_way : free_way;
endmodule

// File: rtl/btb_tgt_ram.sv
module btb_tgt_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/btb.sv
module btb #(
  parameter int         ADDR_W    = 32,
  parameter int         SET_BITS  = 4,
  parameter int         WAYS      = 16,
  parameter logic [7:0] LFSR_SEED = 8'hA5,
  localparam int        WAY_BITS  = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   lk_addr,
  output logic                lk_hit,
  output logic [WAY_BITS-1:0] lk_way,
  output logic [ADDR_W-1:0]   lk_target,
  input  logic                upd_en,
  input  logic [ADDR_W-1:0]   upd_addr,
  input  logic                upd_taken,
  input  logic [ADDR_W-1:0]   upd_target,
  input  logic [ADDR_W-1:0]   upd_next
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS - 2;

  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];
  logic [7:0]                lfsr_q;

  logic [SET_BITS-1:0] lk_set, up_set;
  logic [TAG_W-1:0]    lk_tag, up_tag;
  assign lk_set = lk_addr[SET_BITS+1:2];
  assign lk_tag = lk_addr[ADDR_W-1:SET_BITS+2];
  assign up_set = upd_addr[SET_BITS+1:2];
  assign up_tag = upd_addr[ADDR_W-1:SET_BITS+2];

  logic unused_lowbits;
  assign unused_lowbits = ^{lk_addr[1:0], upd_addr[1:0]};

  logic [WAYS-1:0] lk_match, up_match;
  logic                lk_hit_c, up_hit;
  logic [WAY_BITS-1:0] lk_way_c, up_way;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      up_match[w] = valid_q[up_set][w] && (tag_q[up_set][w] == up_tag);
    end
    lk_hit_c = 1'b0;
    lk_way_c = '0;
    up_hit   = 1'b0;
    up_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lk_match[w]) begin
        lk_hit_c = 1'b1;
        lk_way_c = WAY_BITS'(w);
      end
      if (up_match[w]) begin
        up_hit = 1'b1;
        up_way = WAY_BITS'(w);
      end
    end
  end

  logic [WAY_BITS-1:0] victim;
  logic                use_rnd;

  btb_victim #(.WAYS(WAYS)) u_victim (
    .row_valid (valid_q[up_set]),
    .rnd_way   (lfsr_q[WAY_BITS-1:0]),
    .victim    (victim),
    .use_rnd   (use_rnd)
  );

  logic alloc, retarget, wr_en;
  logic [WAY_BITS-1:0] wr_way;
  assign alloc    = upd_en && upd_taken && !up_hit && (upd_target != upd_next);
  assign retarget = upd_en && upd_taken && up_hit;
  assign wr_en    = alloc || retarget;
  assign wr_way   = up_hit ? up_way : victim;

  btb_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .adv   (alloc && use_rnd),
    .state (lfsr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (alloc) valid_q[up_set][wr_way] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (alloc) tag_q[up_set][wr_way] <= up_tag;
  end

  logic [ADDR_W-1:0] rd_tgt [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    btb_tgt_ram #(.DEPTH(SETS), .DW(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (wr_en && (wr_way == WAY_BITS'(g))),
      .waddr (up_set),
      .wdata (upd_target),
      .raddr (lk_set),
      .rdata (rd_tgt[g])
    );
  end

  logic                hit_q;
  logic [WAY_BITS-1:0] way_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      way_q <= '0;
    end else begin
      hit_q <= lk_hit_c;
      way_q <= lk_way_c;
    end
  end

  assign lk_hit    = hit_q;
  assign lk_way    = way_q;
  assign lk_target = hit_q ? rd_tgt[way_q] : '0;
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int N      = 256,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_en,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target,
  input logic [ADDR_W-1:0] upd_next,
  input logic [N-1:0]      valid_vec,
  input logic [7:0]        lfsr_state
);
  AST_VALID_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(valid_vec) >= $past($countones(valid_vec))); // R7
  AST_NOT_TAKEN_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    upd_en && !upd_taken |=> $stable(valid_vec)); // R4
  AST_SELF_JUMP_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    upd_en && (upd_target == upd_next) |=> $stable(valid_vec)); // R6
  AST_ALLOC_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    upd_en && upd_taken |=> $countones(valid_vec) <= $past($countones(valid_vec)) + 1); // R5
  AST_LFSR_NOT_STUCK: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != 8'h00); // R9
endmodule

bind btb btb_chk #(.N(SETS * WAYS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .upd_en     (upd_en),
  .upd_taken  (upd_taken),
  .upd_target (upd_target),
  .upd_next   (upd_next),
  .valid_vec  (valid_q),
  .lfsr_state (lfsr_q)
);

// File: tb/sim_btb.sv
module sim_btb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] SEED = 8'hA5;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] lk_addr = 0;
  logic        lk_hit;
  logic [3:0]  lk_way;
  logic [31:0] lk_target;
  logic        upd_en = 0;
  logic [31:0] upd_addr = 0;
  logic        upd_taken = 0;
  logic [31:0] upd_target = 0;
  logic [31:0] upd_next = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb #(.LFSR_SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_way(lk_way),
    .lk_target(lk_target), .upd_en(upd_en), .upd_addr(upd_addr),
    .upd_taken(upd_taken), .upd_target(upd_target), .upd_next(upd_next)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  bit          mv [16][16];
  logic [25:0] mt [16][16];
  logic [31:0] mg [16][16];
  logic [7:0]  mlfsr;

  task automatic m_clear();
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 16; w++) mv[s][w] = 0;
    mlfsr = SEED;
  endtask

  task automatic m_find(input logic [31:0] a, output bit h, output int way);
    h = 0; way = 0;
    for (int w = 15; w >= 0; w--)
      if (mv[a[5:2]][w] && mt[a[5:2]][w] == a[31:6]) begin h = 1; way = w; end
  endtask

  task automatic m_update(input logic [31:0] a, input bit tk,
                          input logic [31:0] tg, input logic [31:0] nx);
    bit h; int way; int s;
    s = a[5:2];
    m_find(a, h, way);
    if (!tk) return;
    if (h) begin mg[s][way] = tg; return; end
    if (tg == nx) return;
    way = -1;
    for (int w = 15; w >= 0; w--) if (!mv[s][w]) way = w;
    if (way < 0) begin
      way = mlfsr[3:0];
      mlfsr = {mlfsr[6:0], mlfsr[7] ^ mlfsr[5] ^ mlfsr[4] ^ mlfsr[3]};
    end
    mv[s][way] = 1; mt[s][way] = a[31:6]; mg[s][way] = tg;
  endtask

  // called at a falling edge; one lookup plus optional update per call
  task automatic step(input logic [31:0] la, input bit ue, input logic [31:0] ua,
                      input bit ut, input logic [31:0] utg, input logic [31:0] un,
                      input string req);
    bit eh; int ew; logic [31:0] et;
    m_find(la, eh, ew);
    et = eh ? mg[la[5:2]][ew] : 32'h0;
    if (!eh) ew = 0;
    lk_addr = la; upd_en = ue; upd_addr = ua; upd_taken = ut;
    upd_target = utg; upd_next = un;
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (lk_hit !== eh || lk_way !== ew[3:0] || lk_target !== et) begin
      n_bad++;
      $display("FAIL %s addr=%h hit/way/tgt actual %b/%0d/%h expected %b/%0d/%h",
               req, la, lk_hit, lk_way, lk_target, eh, ew, et);
    end
    if (ue) m_update(ua, ut, utg, un);
  endtask

  task automatic look(input logic [31:0] a, input string req);
    step(a, 0, 0, 0, 0, 0, req);
  endtask

  task automatic upd(input logic [31:0] a, input bit tk, input logic [31:0] tg,
                     input logic [31:0] nx, input string req);
    step(32'h0, 1, a, tk, tg, nx, req);
  endtask

  task automatic do_reset();
    upd_en = 0; rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    m_clear();
  endtask

  function automatic logic [31:0] pick_addr();
    return {22'(1 + $urandom % 24), 4'($urandom % 3), 2'($urandom % 4)} << 0;
  endfunction

  initial begin
    void'($urandom(32'h1234_5678));
    m_clear();
    @(negedge clk);
    do_reset();
    look(32'h0000_1000, "R1");
    look(32'h0000_0100, "R2");
    upd(32'h0000_0100, 0, 32'h2000, 32'h102, "R4");
    look(32'h0000_0100, "R4");
    upd(32'h0000_0100, 1, 32'h2000, 32'h102, "R5");
    look(32'h0000_0100, "R5");
    look(32'h0000_0103, "R3");
    look(32'h0000_0104, "R3");
    upd(32'h0000_0208, 1, 32'h20A, 32'h20A, "R6");
    look(32'h0000_0208, "R6");
    upd(32'h0000_0101, 0, 32'h0, 32'h102, "R7");
    look(32'h0000_0100, "R7");
    upd(32'h0000_0100, 1, 32'h3000, 32'h102, "R8");
    look(32'h0000_0102, "R8");
    step(32'h0000_0300, 1, 32'h0000_0300, 1, 32'h4444, 32'h302, "R10");
    look(32'h0000_0300, "R10");
    for (int i = 1; i <= 17; i++)
      upd((i << 6) | (5 << 2), 1, 32'h5000 + i, (i << 6) | 32'h16, "R9");
    for (int i = 1; i <= 17; i++)
      look((i << 6) | (5 << 2), "R9");
    look(32'h0000_0100, "R9");
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] a, nx, tg;
      a  = {22'(1 + $urandom % 24), 4'($urandom % 3), 2'($urandom % 4)};
      nx = a + 1 + ($urandom % 5);
      tg = ($urandom % 7 == 0) ? nx : $urandom;
      step(pick_addr(), ($urandom % 4) != 0, a, ($urandom % 5) < 3, tg, nx, "R9");
    end
    do_reset();
    look(32'h0000_0100, "R1");
    look(32'h0000_0300, "R1");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule